// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 16K words by 4 bits. The host hands over one word access at a time on a valid/ready port: a direction bit, a 14-bit word address and, for a store, a 4-bit value. The sequencer then drives the active-low select strobe, the active-low write strobe, the address and the shared data pins. Each phase lasts long enough to meet the memory's minimum times. Those times are given as parameters in nanoseconds and turned into whole clock cycles using a clock-period parameter.

The controller has six named states. `ST_IDLE` waits for a request and is the only state that raises `host_ready`. A store passes through `ST_WSET`, where the address and data are presented with both strobes high, then `ST_WPULSE`, where both strobes are low together, then `ST_WREC`, where both strobes are high and the drivers are released. A load passes through `ST_RACC`, where select is low and write is high while the memory drives data, then `ST_RREL`, where select is high while the memory lets go of the bus.

The transitions are:
- `ST_IDLE`→`ST_WSET` on an accepted store, and `ST_IDLE`→`ST_RACC` on an accepted load.
- `ST_WSET`→`ST_WPULSE`→`ST_WREC`→`ST_IDLE` and `ST_RACC`→`ST_RREL`→`ST_IDLE`. Each of these happens on the last cycle of the current phase's counter.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mem_cs_n` and `mem_we_n` are 1, `host_ready` is 1 and `rd_valid` is 0.
- R2: A store holds `mem_cs_n` and `mem_we_n` low together for `PULSE_C` consecutive cycles, where `PULSE_C` is the largest of the converted write-pulse, select-to-end, address-to-end and data-setup times (2 at defaults). `mem_addr` does not change while both strobes are low.
- R3: After a store's strobes rise, the block stays busy for `RECOV_C` cycles (at least 1, and enough that setup plus pulse plus recovery covers the write cycle time). `host_ready` returns 1 + `PULSE_C` + `RECOV_C` + 1 cycles after acceptance (5 at defaults).
- R4: The block drives `mem_dq` only in `ST_WSET` and `ST_WPULSE`. It never drives while `mem_cs_n`=0 and `mem_we_n`=1.
- R5: A load holds `mem_cs_n`=0 and `mem_we_n`=1 for `ACC_C` cycles, the largest of the converted read-cycle, address-access and select-access times (3 at defaults). The data pins are sampled on the last of those cycles.
- R6: `rd_valid` is a one-cycle pulse carrying that sample on `rd_data`. It is seen `ACC_C`+1 cycles after acceptance (4 at defaults).
- R7: After a load, `mem_cs_n` stays 1 for `REL_C` cycles (converted output-off time) before `host_ready` returns. The block's drivers are off for at least one full cycle before `mem_cs_n` falls for a load.
- R8: `mem_cs_n` and `mem_we_n` fall on the same clock edge in a store. `mem_cs_n` is never low in the cycle before a store's overlap begins.
- R9: `host_ready` is 1 only in `ST_IDLE`. A request is taken when `host_valid` and `host_ready` are both 1, and the address, direction and data are captured at that edge. `host_we`=1 selects a store, 0 a load.
- R10: Each time parameter becomes cycles as ceil(ns / `CLK_NS`), with a floor of one cycle per phase, so a 0 ns setup still takes one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_valid | input | 1 | Request present |
| host_we | input | 1 | 1 = store, 0 = load |
| host_addr | input | 14 | Word address |
| host_wdata | input | 4 | Store value |
| host_ready | output | 1 | Request accepted this cycle when valid |
| rd_valid | output | 1 | One-cycle load result strobe |
| rd_data | output | 4 | Load result |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 14 | Memory address |
| mem_dq | inout | 4 | Shared memory data pins |

## Verification
Some properties are checked on every cycle: the address holds while both strobes are low, the block never drives during a memory read, and the drivers are idle in the cycle before a load's select falls. The checks also cover the strobe-low count against `PULSE_C`, the single-cycle `rd_valid` pulse, and `host_ready` appearing only with both strobes high. Other behaviour only the bench scenarios can show. These are: that stored values come back intact at several addresses, that loads are sampled on the last cycle of the access window rather than earlier, and the exact handshake latencies. The bench's memory model returns wrong data until the access time has passed, which is how it shows the sampling cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPULSE,
        ST_WREC,
        ST_RACC,
        ST_RREL
    } ctl_state_e;

    // ceiling division of a time in ns by the clock period, never below one
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_dqdrv.sv
module asram_dqdrv #(
    parameter int DW = 4
) (
    input  logic          oe,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd,
    inout  wire  [DW-1:0] pad
);
    assign pad = oe ? wd : {DW{1'bz}};
    assign rd  = pad;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int AW     = 14,
    parameter int DW     = 4,
    parameter int T_AS   = 0,
    parameter int T_WP   = 20,
    parameter int T_CW   = 20,
    parameter int T_AWE  = 20,
    parameter int T_DW   = 13,
    parameter int T_WR   = 0,
    parameter int T_WC   = 20,
    parameter int T_RC   = 25,
    parameter int T_AA   = 25,
    parameter int T_ACS  = 25,
    parameter int T_HZ   = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_valid,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    inout  wire  [DW-1:0] mem_dq
);
    // R10: phase lengths in cycles
    localparam int SETUP_C = ns2cyc(T_AS, CLK_NS);
    localparam int PULSE_C = imax(imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_CW, CLK_NS)),
                                  imax(ns2cyc(T_AWE, CLK_NS), ns2cyc(T_DW, CLK_NS)));
    localparam int RECOV_C = imax(ns2cyc(T_WR, CLK_NS),
                                  ns2cyc(T_WC, CLK_NS) - SETUP_C - PULSE_C);
    localparam int ACC_C   = imax(ns2cyc(T_RC, CLK_NS),
                                  imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_ACS, CLK_NS)));
    localparam int REL_C   = ns2cyc(T_HZ, CLK_NS);
    localparam int MAX_C   = imax(imax(imax(SETUP_C, PULSE_C), imax(RECOV_C, ACC_C)), REL_C);
    localparam int CNT_W   = $clog2(MAX_C + 1) + 1;

    ctl_state_e        state_q, state_d;
    logic              t_load, t_last;
    logic [CNT_W-1:0]  t_len;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wd_q, dq_in, rd_q;
    logic              rv_q, drv_en;
    logic              accept;

    function automatic logic [CNT_W-1:0] len_of(input ctl_state_e s);
        unique case (s)
            ST_WSET:   return CNT_W'(SETUP_C);
            ST_WPULSE: return CNT_W'(PULSE_C);
            ST_WREC:   return CNT_W'(RECOV_C);
            ST_RACC:   return CNT_W'(ACC_C);
            ST_RREL:   return CNT_W'(REL_C);
            default:   return CNT_W'(1);
        endcase
    endfunction

    assign accept = host_valid && host_ready;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (host_valid) state_d = host_we ? ST_WSET : ST_RACC;
            ST_WSET:   if (t_last) state_d = ST_WPULSE;
            ST_WPULSE: if (t_last) state_d = ST_WREC;
            ST_WREC:   if (t_last) state_d = ST_IDLE;
            ST_RACC:   if (t_last) state_d = ST_RREL;
            ST_RREL:   if (t_last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign t_load = (state_d != state_q);
    assign t_len  = len_of(state_d);

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .len  (t_len),
        .last (t_last)
    );

    // outputs decoded from state
    always_comb begin
        mem_cs_n   = 1'b1;
        mem_we_n   = 1'b1;
        drv_en     = 1'b0;
        host_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:   host_ready = 1'b1;
            ST_WSET:   drv_en = 1'b1;
            ST_WPULSE: begin
                mem_cs_n = 1'b0;
                mem_we_n = 1'b0;
                drv_en   = 1'b1;
            end
            ST_WREC:   ;
            ST_RACC:   mem_cs_n = 1'b0;
            ST_RREL:   ;
            default:   ;
        endcase
    end

    // request capture and load result
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
            rv_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= host_addr;
                wd_q   <= host_wdata;
            end
            rv_q <= (state_q == ST_RACC) && t_last;
            if ((state_q == ST_RACC) && t_last) rd_q <= dq_in;
        end
    end

    asram_dqdrv #(.DW(DW)) u_dq (
        .oe  (drv_en),
        .wd  (wd_q),
        .rd  (dq_in),
        .pad (mem_dq)
    );

    assign mem_addr = addr_q;
    assign rd_valid = rv_q;
    assign rd_data  = rd_q;

    // ---------------- checks ----------------
    logic [CNT_W-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)                        low_run <= '0;
        else if (!mem_cs_n && !mem_we_n) low_run <= low_run + CNT_W'(1);
        else                            low_run <= '0;
    end

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !mem_we_n) |-> $stable(mem_addr));

    a_r2_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (low_run >= CNT_W'(PULSE_C)));

    a_r4_no_contend: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (mem_cs_n || !mem_we_n));

    a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_cs_n) && mem_we_n) |-> !$past(drv_en));

    a_r8_we_first: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $fell(mem_cs_n));

    a_r6_rv_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r9_ready_idle: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (mem_cs_n && mem_we_n && !drv_en));
endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_we = 1'b0;
    logic [13:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic        host_ready, rd_valid, mem_cs_n, mem_we_n;
    logic [3:0]  rd_data;
    logic [13:0] mem_addr;
    wire  [3:0]  mem_dq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    asram_ctrl dut (
        .clk(clk), .rst(rst),
        .host_valid(host_valid), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // memory model: 64 words keyed by low address bits; wrong data until
    // select has been low for two edges
    logic [3:0] mdl [64];
    int         age = 0;
    logic       mdl_oe;
    logic [3:0] mdl_val;
    assign mdl_oe  = !mem_cs_n && mem_we_n;
    assign mdl_val = (age >= 2) ? mdl[mem_addr[5:0]] : ~mdl[mem_addr[5:0]];
    assign mem_dq  = mdl_oe ? mdl_val : 4'bz;

    always @(posedge clk) age <= (!mem_cs_n && mem_we_n) ? age + 1 : 0;

    // bus monitor at the falling edge
    bit          prev_both = 0, prev_cs_low = 0;
    logic [13:0] prev_addr = '0;
    int          run = 0, last_run = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n && !mem_we_n) begin
                mdl[mem_addr[5:0]] = mem_dq;
                if (prev_both && mem_addr != prev_addr) begin
                    n_bad++; $display("FAIL R2 addr moved act=%h exp=%h", mem_addr, prev_addr);
                end
                if (!prev_both && prev_cs_low) begin
                    n_bad++; $display("FAIL R8 select led write act=1 exp=0");
                end
                run++;
            end else begin
                if (prev_both) last_run = run;
                run = 0;
            end
            prev_both   = !mem_cs_n && !mem_we_n;
            prev_cs_low = !mem_cs_n;
            prev_addr   = mem_addr;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 cs_n", mem_cs_n, 1);
        check("R1 we_n", mem_we_n, 1);
        check("R1 ready", host_ready, 1);
        check("R1 rvalid", rd_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cs_n post", mem_cs_n, 1);
        check("R1 ready post", host_ready, 1);
    endtask

    task automatic do_write(input logic [13:0] a, input logic [3:0] d);
        int k;
        while (!host_ready) @(negedge clk);
        host_valid = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 0; host_addr = '1; host_wdata = ~d;
        k = 1;
        check("R9 ready busy", host_ready, 0);
        while (!host_ready && k < 50) begin @(negedge clk); k++; end
        check("R3 write latency", k, 5);
        check("R2 pulse cycles", last_run, 2);
    endtask

    task automatic do_read(input logic [13:0] a, input logic [3:0] exp);
        int k;
        while (!host_ready) @(negedge clk);
        host_valid = 1; host_we = 0; host_addr = a;
        @(negedge clk);
        host_valid = 0; host_addr = '0;
        k = 1;
        check("R5 select low", mem_cs_n, 0);
        check("R5 we high", mem_we_n, 1);
        while (!rd_valid && k < 50) begin @(negedge clk); k++; end
        check("R6 read latency", k, 4);
        check("R5 read data", rd_data, exp);
        @(negedge clk);
        check("R6 pulse width", rd_valid, 0);
        check("R7 release cs", mem_cs_n, 1);
        check("R7 ready after release", host_ready, 1);
    endtask

    task automatic t_patterns;
        do_write(14'h0003, 4'h5);
        do_read (14'h0003, 4'h5);
        do_write(14'h3FC7, 4'hA);
        do_write(14'h1008, 4'hF);
        do_read (14'h3FC7, 4'hA);
        do_read (14'h1008, 4'hF);
        do_write(14'h0003, 4'h0);
        do_read (14'h0003, 4'h0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = 4'h0;
        repeat (3) @(posedge clk);
        t_reset();
        t_patterns();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule